// File: doc/BRIEF.md
# Sampled Phase-Frequency Detector with Lock Filter

This block compares two divided clocks, a reference and a feedback, against each other on their rising edges. A sampling clock `clk` runs it. Both inputs pass through a synchronizer and a rising-edge detector before they reach two internal flags. The flag for the input whose edge arrives first drives its active-low output low. That output stays low until the other input's edge arrives. Both flags then clear together.

When the reference leads, `up_n` pulses low, which asks the loop to raise the oscillator frequency. When the feedback leads, `dn_n` pulses low, which asks for a lower frequency. The pulse width, counted in sampling cycles, grows with the phase offset.

A combined activity output `act` is high whenever either pulse output is low. A run-length counter watches `act` and acts as the low-pass filter for lock detection. Each burst of activity is one comparison. `locked` rises after a set number of consecutive short bursts. It falls as soon as a single burst grows too long.

Top module: `pfd_lock_top`

## Requirements
- R1: Only rising edges of `ref_in` and `fb_in` start pulses. A falling edge on either input leaves `up_n` and `dn_n` high.
- R2: When the `fb_in` edge arrives d sampling cycles before the `ref_in` edge, `dn_n` is low for d+1 consecutive cycles and `up_n` is low for 1 cycle.
- R3: When the `ref_in` edge arrives d sampling cycles before the `fb_in` edge, `up_n` is low for d+1 consecutive cycles and `dn_n` is low for 1 cycle.
- R4: Rising edges on both inputs in the same cycle drive `up_n` and `dn_n` low together for exactly one cycle.
- R5: In every cycle, `act` equals the NAND of `up_n` and `dn_n`.
- R6: Once `up_n` and `dn_n` are low together, both return high on the next cycle. They are never low together for two cycles in a row.
- R7: Each maximal run of cycles with `act` high is one comparison. A comparison counts as good when its run length is at most WIDTH_LIMIT. `locked` rises after LOCK_COUNT consecutive good comparisons. It updates on the clock edge that ends the first cycle with `act` low.
- R8: When `act` has been high for WIDTH_LIMIT+1 consecutive cycles, `locked` is cleared by the clock edge that ends that cycle, and the count of good comparisons restarts from zero.
- R9: While `rst` is high, and on the cycle after it, `up_n` and `dn_n` are high and `act` and `locked` are low.
- R10: An input rise that `clk` first captures at edge k drives the leading output low from clock edge k+SYNC_STAGES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Divided reference clock |
| fb_in | input | 1 | Divided feedback clock |
| up_n | output | 1 | Active-low request to raise the frequency |
| dn_n | output | 1 | Active-low request to lower the frequency |
| act | output | 1 | High while either pulse output is low |
| locked | output | 1 | Filtered lock indication |

## Verification
Two events can fall in the same cycle.

The first is a pair of input edges landing together. Here the set of both flags collides with the mutual clear. The bench provokes it by raising `ref_in` and `fb_in` in the same cycle, and also at every lead or lag from one to six cycles. For each case it checks the width of each pulse and that exactly one cycle has both outputs low.

The second is the lock filter scoring the end of a comparison in the same cycle that its run counter would cross the limit. The bench provokes this with bursts one cycle shorter than the limit, equal to it, and one longer. While the detector is locked, a long burst must leave `locked` visible for exactly WIDTH_LIMIT+1 active samples.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Increment that stops at a ceiling value.
  function automatic int unsigned sat_inc(input int unsigned v, input int unsigned ceil);
    return (v >= ceil) ? ceil : v + 1;
  endfunction

  // Phase of a comparison as seen by the lock filter.
  typedef enum logic [1:0] {
    CMP_IDLE  = 2'd0,
    CMP_BUSY  = 2'd1,
    CMP_GOOD  = 2'd2,
    CMP_LONG  = 2'd3
  } cmp_state_e;

endpackage

// File: rtl/pfd_sync_edge.sv
module pfd_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sig_in,
  output logic rise
);
  localparam int NS = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

  logic [NS-1:0] chain;
  logic          last_q;

  generate
    if (NS == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= sig_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[NS-2:0], sig_in};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[NS-1];
  end

  assign rise = chain[NS-1] & ~last_q;
endmodule

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk,
  input  logic rst,
  input  logic ref_rise,
  input  logic fb_rise,
  output logic up_n,
  output logic dn_n,
  output logic act
);
  logic up_q, dn_q;
  logic up_nx, dn_nx, both;

  assign both = up_q & dn_q;

  always_comb begin
    if (both) begin
      up_nx = 1'b0;
      dn_nx = 1'b0;
    end else begin
      up_nx = up_q | ref_rise;
      dn_nx = dn_q | fb_rise;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
      act  <= 1'b0;
    end else begin
      up_q <= up_nx;
      dn_q <= dn_nx;
      act  <= up_nx | dn_nx;
    end
  end

  assign up_n = ~up_q;
  assign dn_n = ~dn_q;
endmodule

// File: rtl/pfd_lock_filter.sv
module pfd_lock_filter
  import pfd_pkg::*;
#(
  parameter int LOCK_COUNT  = 16,
  parameter int WIDTH_LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic act,
  output logic locked
);
  localparam int RUN_MAX = WIDTH_LIMIT + 1;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);
  localparam int GOOD_W  = $clog2(LOCK_COUNT + 1);

  logic [RUN_W-1:0]  run_q;
  logic [GOOD_W-1:0] good_q;
  cmp_state_e        st;

  always_comb begin
    if (act) begin
      st = (run_q == RUN_W'(WIDTH_LIMIT)) ? CMP_LONG : CMP_BUSY;
    end else if (run_q != '0 && run_q <= RUN_W'(WIDTH_LIMIT)) begin
      st = CMP_GOOD;
    end else begin
      st = CMP_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= '0;
      good_q <= '0;
      locked <= 1'b0;
    end else begin
      if (act) run_q <= RUN_W'(sat_inc(run_q, RUN_MAX));
      else     run_q <= '0;
      case (st)
        CMP_LONG: begin
          good_q <= '0;
          locked <= 1'b0;
        end
        CMP_GOOD: begin
          good_q <= GOOD_W'(sat_inc(good_q, LOCK_COUNT));
          locked <= (sat_inc(good_q, LOCK_COUNT) >= LOCK_COUNT);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pfd_lock_top.sv
module pfd_lock_top #(
  parameter int SYNC_STAGES = 2,
  parameter int LOCK_COUNT  = 16,
  parameter int WIDTH_LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic fb_in,
  output logic up_n,
  output logic dn_n,
  output logic act,
  output logic locked
);
  logic ref_rise, fb_rise;

  pfd_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_ref_edge (
    .clk(clk), .rst(rst), .sig_in(ref_in), .rise(ref_rise)
  );

  pfd_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_fb_edge (
    .clk(clk), .rst(rst), .sig_in(fb_in), .rise(fb_rise)
  );

  pfd_core u_core (
    .clk(clk), .rst(rst), .ref_rise(ref_rise), .fb_rise(fb_rise),
    .up_n(up_n), .dn_n(dn_n), .act(act)
  );

  pfd_lock_filter #(.LOCK_COUNT(LOCK_COUNT), .WIDTH_LIMIT(WIDTH_LIMIT)) u_lock (
    .clk(clk), .rst(rst), .act(act), .locked(locked)
  );
endmodule

// File: rtl/pfd_lock_chk.sv
module pfd_lock_chk (
  input logic clk,
  input logic rst,
  input logic up_n,
  input logic dn_n,
  input logic act,
  input logic locked
);
  // R5
  act_nand_chk: assert property (@(posedge clk) disable iff (rst)
    act == !(up_n && dn_n));

  // R6
  joint_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (!up_n && !dn_n) |=> (up_n && dn_n));

  // R9
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (up_n && dn_n && !act && !locked));

  // R7
  lock_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> !$past(act));

  // R8
  lock_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(act));
endmodule

bind pfd_lock_top pfd_lock_chk u_chk (
  .clk(clk), .rst(rst), .up_n(up_n), .dn_n(dn_n), .act(act), .locked(locked)
);

// File: tb/sim_pfd_lock_top.sv
module sim_pfd_lock_top;
  localparam int SYNC  = 2;
  localparam int NLOCK = 4;
  localparam int LIM   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0, fb_in = 1'b0;
  logic up_n, dn_n, act, locked;

  int checks = 0, fails = 0;
  int good = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pfd_lock_top #(.SYNC_STAGES(SYNC), .LOCK_COUNT(NLOCK), .WIDTH_LIMIT(LIM)) u0 (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
    .up_n(up_n), .dn_n(dn_n), .act(act), .locked(locked)
  );

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  // d > 0: ref leads by d cycles; d < 0: fb leads by -d cycles.
  task automatic compare(input int d);
    int ad, upw, dnw, both, nand_bad, first_up, first_dn, act_lk, was_locked, post;
    ad = (d < 0) ? -d : d;
    upw = 0; dnw = 0; both = 0; nand_bad = 0; first_up = 0; first_dn = 0;
    act_lk = 0; post = 0;
    was_locked = locked;
    @(negedge clk);
    if (d >= 0) ref_in = 1'b1;
    if (d <= 0) fb_in = 1'b1;
    for (int i = 1; i <= 24; i++) begin
      @(negedge clk);
      if (!up_n) begin upw++; if (first_up == 0) first_up = i; end
      if (!dn_n) begin dnw++; if (first_dn == 0) first_dn = i; end
      if (!up_n && !dn_n) both++;
      if (act != !(up_n && dn_n)) nand_bad++;
      if (act && locked) act_lk++;
      if (i == ad && d != 0) begin
        ref_in = 1'b1;
        fb_in = 1'b1;
      end
    end
    chk((d > 0) ? "R3 up width" : "R2 up width", upw, (d > 0) ? ad + 1 : 1);
    chk((d < 0) ? "R2 dn width" : "R3 dn width", dnw, (d < 0) ? ad + 1 : 1);
    chk("R4 R6 coincident cycles", both, 1);
    chk("R5 act nand", nand_bad, 0);
    if (d > 0) chk("R10 leading latency", first_up, SYNC + 1);
    if (d < 0) chk("R10 leading latency", first_dn, SYNC + 1);
    if (was_locked && ad + 1 > LIM) chk("R8 early drop", act_lk, LIM + 1);
    if (ad + 1 <= LIM) good = (good + 1 > NLOCK) ? NLOCK : good + 1;
    else good = 0;
    chk("R7 R8 lock state", locked, (good == NLOCK) ? 1 : 0);
    ref_in = 1'b0;
    fb_in = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!up_n || !dn_n) post++;
    end
    chk("R1 falling edges ignored", post, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R9 reset up_n", up_n, 1);
    chk("R9 reset dn_n", dn_n, 1);
    chk("R9 reset act", act, 0);
    chk("R9 reset locked", locked, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // Sweep of leads and lags, both directions.
    for (int d = -6; d <= 6; d++) compare(d);
    // Reach lock with short bursts around the limit.
    compare(0); compare(1); compare(-2); compare(2); compare(0);
    // Long burst while locked: early drop.
    compare(5);
    // Relock, then exactly-at-limit and one-over bursts.
    for (int k = 0; k < NLOCK; k++) compare(k % 2 == 0 ? LIM - 1 : -(LIM - 1));
    compare(-(LIM));
    for (int k = 0; k < NLOCK; k++) compare(0);
    compare(-6);
    // Lone falling-edge stimulus on one input.
    ref_in = 1'b1;
    repeat (10) @(negedge clk);
    fb_in = 1'b1;
    repeat (10) @(negedge clk);
    ref_in = 1'b0;
    begin
      int lows;
      lows = 0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (!up_n || !dn_n) lows++;
      end
      chk("R1 lone falling edge", lows, 0);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule